// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block gathers interrupt requests from a group of external pins, a group of peripheral sources and one non-maskable line. It presents a single winning request to the processor. Each maskable source has an enable bit and a sticky request flag. Software writes the enables and clears the flags through a small register port.

Each cycle in which no request is being presented, the block picks the highest-priority eligible source. It checks maskable sources against the global mask bit taken from the processor status word. It then raises `irq_valid` together with the winner's index. The index stays fixed until the processor acknowledges it. Sources that lose arbitration, or that are blocked by the mask, stay latched and are presented later. The non-maskable line is detected on its rising edge and ignores both the enables and the mask. A level already high while reset is applied is not taken.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable register and the flag register read 0 and `irq_valid` is low. A non-maskable line held high through reset and beyond is not accepted.
- R2: A write with `reg_addr`=0 loads the enable register. Bit k (k < N_PIN) belongs to pin k and bit N_PIN+j to peripheral j. A flag bit becomes set only when its request is high in a cycle in which its enable bit is 1.
- R3: A set flag stays set until a write with `reg_addr`=1 carries a 1 in that bit position (write-one-to-clear). Acknowledging a maskable source does not clear its flag.
- R4: Index 0 is the non-maskable source, pin k is index k+1 and peripheral j is index N_PIN+1+j. When several sources are eligible, the lowest index wins.
- R5: While `mask_i` is 1, no maskable source is presented and its flag stays set. Once `mask_i` returns to 0, the pending source is presented.
- R6: A rising edge on `nmi_in` is presented as index 0 even when `mask_i` is 1. It is taken once per edge and its pending state clears on acknowledge.
- R7: Clearing an enable bit while its flag is set stops that source from being presented but leaves the flag set. Setting the enable again makes it eligible.
- R8: Once `irq_valid` is high, it and `irq_idx` hold unchanged until a cycle with `irq_ack` high. `irq_valid` is low in the cycle after that acknowledge.
- R9: Sources that lose arbitration stay pending and are presented in priority order after each earlier winner is acknowledged and cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| pin_req | input | N_PIN | Requests from external pins |
| per_req | input | N_PER | Requests from peripheral sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects enables, 1 selects flags |
| reg_wdata | input | N_PIN+N_PER | Write data: enable value, or ones to clear flags |
| reg_rdata | output | N_PIN+N_PER | Read data of the register selected by `reg_addr` |
| mask_i | input | 1 | Global mask bit from the processor status word |
| irq_ack | input | 1 | Processor acknowledge of the presented request |
| irq_valid | output | 1 | A request is being presented |
| irq_idx | output | $clog2(N_PIN+N_PER+1) | Index of the presented source |

## Verification
The assertions assume three things about the inputs. `irq_ack` arrives only while `irq_valid` is high. Flags are removed only by the clear write. No request line stays high past the cycle in which software clears its flag. The stimulus gives each maskable request as a one-cycle pulse. It acknowledges only a presented index, holding it for a few cycles first. It issues the matching clear write in the same cycle as the acknowledge, except where a test deliberately leaves the flag in place. Register writes from the test sequence are issued only while nothing is being presented, so they never collide with the acknowledge traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_FLAGS  = 1'b1
    } irqc_reg_e;

endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             en_we,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] flag_q
);

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (en_we) begin
            bank_d.en = wdata;
        end
        // a new request wins over a clear in the same cycle
        bank_d.flag = (bank_q.flag & ~(clr_we ? wdata : '0)) | (src_req & bank_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_q   = bank_q.en;
    assign flag_q = bank_q.flag;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !$past(flag_q[g])) |-> $past(src_req[g] && en_q[g])); // R2
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flag_q[g]) && !flag_q[g]) |-> $past(clr_we && wdata[g])); // R3
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic             nmi_pend,
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    input  logic             mask,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [N_SRC-1:0] live;

    assign live = flags & enables & {N_SRC{~mask}};

    always_comb begin
        hit = 1'b0;
        idx = '0;
        // scan from lowest priority so the lowest index is written last
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i + 1);
            end
        end
        if (nmi_pend) begin
            hit = 1'b1;
            idx = '0;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned N_PIN = 4,
    parameter int unsigned N_PER = 4,
    localparam int unsigned N_SRC = N_PIN + N_PER,
    localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic [N_PIN-1:0] pin_req,
    input  logic [N_PER-1:0] per_req,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    input  logic             mask_i,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_idx
);
    import irqc_pkg::*;

    typedef struct packed {
        logic             nmi_prev;
        logic             nmi_pend;
        logic             valid;
        logic [IDX_W-1:0] idx;
    } out_t;

    out_t st_d, st_q;

    logic [N_SRC-1:0] en_q, flag_q;
    logic             en_we, clr_we;
    logic             arb_hit;
    logic [IDX_W-1:0] arb_idx;
    irqc_reg_e        sel;

    assign sel    = irqc_reg_e'(reg_addr);
    assign en_we  = reg_wr && (sel == REG_ENABLE);
    assign clr_we = reg_wr && (sel == REG_FLAGS);

    irqc_flags #(.N_SRC(N_SRC)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req ({per_req, pin_req}),
        .en_we   (en_we),
        .clr_we  (clr_we),
        .wdata   (reg_wdata),
        .en_q    (en_q),
        .flag_q  (flag_q)
    );

    irqc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) arb_i (
        .nmi_pend (st_q.nmi_pend),
        .flags    (flag_q),
        .enables  (en_q),
        .mask     (mask_i),
        .hit      (arb_hit),
        .idx      (arb_idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = nmi_in;
        if (st_q.valid && irq_ack && (st_q.idx == '0)) begin
            st_d.nmi_pend = 1'b0;
        end
        if (nmi_in && !st_q.nmi_prev) begin
            st_d.nmi_pend = 1'b1;
        end
        if (st_q.valid) begin
            if (irq_ack) begin
                st_d.valid = 1'b0;
            end
        end else begin
            st_d.valid = arb_hit;
            st_d.idx   = arb_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.nmi_prev <= 1'b1;   // a level present in reset is no edge
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_valid = st_q.valid;
    assign irq_idx   = st_q.idx;
    assign reg_rdata = (sel == REG_FLAGS) ? flag_q : en_q;

    localparam logic [N_SRC-1:0] ONE_HOT0 = N_SRC'(1);
    logic [N_SRC-1:0] live_now;
    assign live_now = flag_q & en_q;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_idx))); // R8
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> !irq_valid); // R8
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && (irq_idx != '0)) |-> !$past(mask_i)); // R5
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && (irq_idx != '0))
            |-> (|($past(live_now) & (ONE_HOT0 << (irq_idx - IDX_W'(1)))))); // R7
    AST_NMI_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nmi_pend) |-> $past(nmi_in)); // R6

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NQ = 4;
    localparam int NS = NP + NQ;
    localparam int IW = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_in = 1'b0;
    logic [NP-1:0] pin_req = '0;
    logic [NQ-1:0] per_req = '0;
    logic          reg_wr, reg_addr;
    logic [NS-1:0] reg_wdata, reg_rdata;
    logic          mask_i = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_valid;
    logic [IW-1:0] irq_idx;

    logic          drv_wr = 1'b0, drv_addr = 1'b0;
    logic [NS-1:0] drv_wdata = '0;
    logic          mon_wr = 1'b0;
    logic [NS-1:0] mon_wdata = '0;

    assign reg_wr    = drv_wr | mon_wr;
    assign reg_addr  = mon_wr ? 1'b1 : drv_addr;
    assign reg_wdata = mon_wr ? mon_wdata : drv_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl #(.N_PIN(NP), .N_PER(NQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .pin_req(pin_req), .per_req(per_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mask_i(mask_i), .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_idx(irq_idx)
    );

    // scoreboard: driver appends, monitor consumes with its own pointer
    int exp_q[$];
    int rd_ptr = 0;
    int noclr_req = 0;
    int noclr_used = 0;
    bit mon_busy = 1'b0;
    int mon_vec = 0, mon_err = 0;
    int n_vec = 0, n_err = 0;
    bit wd_fired = 1'b0;
    bit done = 1'b0;

    always begin
        @(negedge clk);
        if (rst_n && irq_valid) begin
            int got;
            bit keep;
            mon_busy = 1'b1;
            got = int'(irq_idx);
            mon_vec++;
            if (rd_ptr >= exp_q.size()) begin
                mon_err++;
                $display("FAIL R4 unexpected request: actual=%0d expected=none", got);
            end else begin
                if (got != exp_q[rd_ptr]) begin
                    mon_err++;
                    $display("FAIL R4/R9 order: actual=%0d expected=%0d", got, exp_q[rd_ptr]);
                end
                rd_ptr++;
            end
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                mon_vec++;
                if (!irq_valid || int'(irq_idx) != got) begin
                    mon_err++;
                    $display("FAIL R8 hold: actual=%0d/%0d expected=1/%0d", irq_valid, irq_idx, got);
                end
            end
            keep = (noclr_req > noclr_used);
            if (keep) noclr_used++;
            irq_ack   = 1'b1;
            mon_wr    = (got != 0) && !keep;
            mon_wdata = (got != 0) ? (NS'(1) << (got - 1)) : '0;
            @(negedge clk);
            irq_ack = 1'b0;
            mon_wr  = 1'b0;
            mon_vec++;
            if (irq_valid) begin
                mon_err++;
                $display("FAIL R8 drop after ack: actual=1 expected=0");
            end
            mon_busy = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [NS-1:0] d);
        drv_wr = 1'b1; drv_addr = a; drv_wdata = d;
        @(negedge clk);
        drv_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [NS-1:0] d);
        drv_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NP-1:0] p, input logic [NQ-1:0] q);
        pin_req = p; per_req = q;
        @(negedge clk);
        pin_req = '0; per_req = '0;
    endtask

    task automatic expect_irq(input int idx);
        exp_q.push_back(idx);
    endtask

    task automatic drain();
        cyc(2);
        while (rd_ptr < exp_q.size() || mon_busy || irq_valid) @(negedge clk);
        cyc(3);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_vec + mon_vec, n_err + mon_err + (wd_fired ? 1 : 0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            wd_fired = 1'b1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] rv;
        // R1: non-maskable level held through reset
        nmi_in = 1'b1;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk(!irq_valid, "R1 valid after reset", irq_valid, 0);
        reg_read(1'b0, rv);
        chk(rv == '0, "R1 enables after reset", rv, 0);
        reg_read(1'b1, rv);
        chk(rv == '0, "R1 flags after reset", rv, 0);
        cyc(6);
        chk(!irq_valid, "R1 nmi level from reset ignored", irq_valid, 0);
        nmi_in = 1'b0;
        cyc(2);

        // R2: enables load and read back
        reg_write(1'b0, '1);
        reg_read(1'b0, rv);
        chk(rv == '1, "R2 enable readback", rv, (1 << NS) - 1);

        // R4: single pin 2 -> index 3
        expect_irq(3);
        pulse(4'b0100, 4'b0000);
        drain();

        // R4 R9: pin1, pin3, per2 together
        expect_irq(2); expect_irq(4); expect_irq(NP + 3);
        pulse(4'b1010, 4'b0100);
        drain();

        // R4: peripheral 0 alone
        expect_irq(NP + 1);
        pulse(4'b0000, 4'b0001);
        drain();

        // R2: disabled source does not set its flag
        reg_write(1'b0, ~NS'(1));
        pulse(4'b0001, 4'b0000);
        cyc(4);
        reg_read(1'b1, rv);
        chk(rv[0] == 1'b0, "R2 disabled flag stays clear", rv[0], 0);
        chk(!irq_valid, "R2 disabled source not presented", irq_valid, 0);
        reg_write(1'b0, '1);

        // R5: mask holds a pending peripheral
        mask_i = 1'b1;
        pulse(4'b0000, 4'b1000);
        cyc(6);
        chk(!irq_valid, "R5 masked not presented", irq_valid, 0);
        reg_read(1'b1, rv);
        chk(rv[NP+3] == 1'b1, "R5 flag pending under mask", rv[NP+3], 1);
        expect_irq(NP + 4);
        mask_i = 1'b0;
        drain();

        // R6: NMI bypasses the mask, long level taken once
        mask_i = 1'b1;
        expect_irq(0);
        nmi_in = 1'b1;
        cyc(12);
        nmi_in = 1'b0;
        drain();
        chk(rd_ptr == exp_q.size(), "R6 nmi taken once", rd_ptr, exp_q.size());
        mask_i = 1'b0;

        // R7: clearing enable suppresses but keeps the flag
        mask_i = 1'b1;
        pulse(4'b0100, 4'b0000);
        reg_write(1'b0, ~NS'(4));
        mask_i = 1'b0;
        cyc(6);
        chk(!irq_valid, "R7 disabled pending not presented", irq_valid, 0);
        reg_read(1'b1, rv);
        chk(rv[2] == 1'b1, "R7 flag kept", rv[2], 1);
        expect_irq(3);
        reg_write(1'b0, '1);
        drain();

        // R3: acknowledge without clear leaves the flag -> presented again
        expect_irq(1); expect_irq(1);
        noclr_req++;
        pulse(4'b0001, 4'b0000);
        drain();
        reg_read(1'b1, rv);
        chk(rv == '0, "R3 flag removed by clear write", rv, 0);

        // R8 R6: NMI arriving while pin 3 is held waits for the ack
        expect_irq(4); expect_irq(0);
        pulse(4'b1000, 4'b0000);
        while (!irq_valid) @(negedge clk);
        nmi_in = 1'b1;
        cyc(2);
        nmi_in = 1'b0;
        drain();
        chk(rd_ptr == exp_q.size(), "R9 all expected consumed", rd_ptr, exp_q.size());

        done = 1'b1;
        report();
        $finish;
    end

endmodule